// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a small 8-bit processor. The bus has 16 address bits. The upper byte has its own lines. The low address byte and the data byte take turns on one shared set of lines. A core-side request starts a read or a write. The block then raises an address-latch strobe, puts the low address and then the data on the shared lines, and drives the read or write strobe.

A slow device can stretch a cycle by holding READY low. The block samples READY on a falling clock edge. Each low sample adds one whole wait clock, and every output holds still during that clock.

An external master can take the bus with a HOLD/HLDA handshake. The block first finishes any cycle that is in progress. It then acknowledges the request and, half a clock later, releases its address, data, status and strobe lines to high impedance. When HOLD is removed, the block takes the bus back and serves the request that was waiting.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is active, `ale`=0, `rd_n`=1, `wr_n`=1, `hlda`=0, `ack`=0, and `a_hi` is driven to 0.
- R2: A request seen at a rising edge while idle, with `ack` low and no bus grant due, starts a cycle at that edge. In the first clock (T1), `ale` is high for the first half only. During T1, `ad` carries `addr[7:0]`, `a_hi` carries `addr[15:8]`, and `io_m` equals the `io` input.
- R3: A read asserts `rd_n` low for T2, any wait clocks and T3. `ad` is captured as `rdata` at the rising edge that ends T3.
- R4: A write drives `wdata` on `ad` and holds `wr_n` low from T2 through T3.
- R5: READY is sampled at each falling edge inside T2 and each wait clock. Every low sample inserts one wait clock before T3, and the strobes, `ad` and `a_hi` stay unchanged. With no waits, a cycle lasts three clocks.
- R6: Status during a cycle: `{s1,s0}` = 2'b10 for a read and 2'b01 for a write.
- R7: HOLD passes through a two-flop synchroniser. It is honoured only at a cycle boundary. `hlda` rises at the rising edge after the synchronised HOLD is seen, which is three edges after HOLD is first sampled. At an idle boundary, HOLD wins over a pending request.
- R8: Half a clock after `hlda` rises, `a_hi`, `ad`, `rd_n`, `wr_n`, `io_m`, `s1` and `s0` go to high impedance. `ale` stays driven low. The lines are driven again half a clock after `hlda` falls.
- R9: Three edges after HOLD is removed, `hlda` falls. The pending request then starts its T1 at the next edge.
- R10: `ack` is high for exactly one clock, the clock after T3, and `rdata` is valid in that clock. A request still high during that clock is not taken as a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Core cycle request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| io | input | 1 | Selects I/O space (driven on io_m) |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, valid with ack |
| a_hi | output | 8 | Upper address lines, tristate |
| ad | inout | 8 | Shared low address / data lines |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active low, tristate |
| wr_n | output | 1 | Write strobe, active low, tristate |
| io_m | output | 1 | Memory/I/O status, tristate |
| s1 | output | 1 | Cycle status bit 1, tristate |
| s0 | output | 1 | Cycle status bit 0, tristate |
| ready | input | 1 | Device ready, sampled on falling edges |
| hold | input | 1 | External bus request |
| hlda | output | 1 | Bus grant acknowledge |

## Verification
Two events can land in the same clock. First, the completion `ack` of a cycle and the rise of `hlda` coincide when HOLD arrives during T1: the bench raises HOLD in the second half of T1 and expects `ack`, correct `rdata` and `hlda` together, with the lines floating half a clock later. Second, a synchronised HOLD and a waiting request can reach the same idle boundary: the bench times the request to arrive exactly when HOLD clears the synchroniser and expects the grant to win, with the request served four edges after HOLD drops. All floating lines have pull-ups in the bench, so a released line reads as all ones.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic          io,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-DW-1:0] a_hi,
  inout  wire  [DW-1:0] ad,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          io_m,
  output logic          s1,
  output logic          s0,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);

  typedef enum logic [2:0] {IDLE, T1, T2, TW, T3, HLD} st_t;

  st_t st;
  logic hs1, hs2, half, rdy_s, flt, ack_r;
  logic we_r, io_r;
  logic [AW-1:0] a_r;
  logic [DW-1:0] wd_r, rd_r;

  logic busy, drv, ad_oe;
  logic [DW-1:0] ad_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      hs1   <= 1'b0;
      hs2   <= 1'b0;
      ack_r <= 1'b0;
      a_r   <= '0;
      we_r  <= 1'b0;
      io_r  <= 1'b0;
      wd_r  <= '0;
      rd_r  <= '0;
    end else begin
      hs1   <= hold;
      hs2   <= hs1;
      ack_r <= (st == T3);
      case (st)
        IDLE: begin
          if (hs2) st <= HLD;
          else if (req && !ack_r) begin
            st   <= T1;
            a_r  <= addr;
            we_r <= we;
            io_r <= io;
            wd_r <= wdata;
          end
        end
        T1:      st <= T2;
        T2, TW:  st <= rdy_s ? T3 : TW;
        T3: begin
          if (!we_r) rd_r <= ad;
          st <= hs2 ? HLD : IDLE;
        end
        HLD:     if (!hs2) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half  <= 1'b0;
      rdy_s <= 1'b0;
      flt   <= 1'b0;
    end else begin
      half  <= (st == T1);
      rdy_s <= ready;
      flt   <= (st == HLD);
    end
  end

  assign busy  = (st == T2) || (st == TW) || (st == T3);
  assign drv   = !flt;
  assign ad_oe = drv && ((st == T1) || (we_r && busy));
  assign ad_o  = (st == T1) ? a_r[DW-1:0] : wd_r;

  assign ad    = ad_oe ? ad_o : 'z;
  assign a_hi  = drv ? a_r[AW-1:DW] : 'z;
  assign rd_n  = drv ? !(busy && !we_r) : 1'bz;
  assign wr_n  = drv ? !(busy && we_r) : 1'bz;
  assign io_m  = drv ? io_r : 1'bz;
  assign s1    = drv ? !we_r : 1'bz;
  assign s0    = drv ? we_r : 1'bz;
  assign ale   = (st == T1) && !half;
  assign hlda  = (st == HLD);
  assign ack   = ack_r;
  assign rdata = rd_r;

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_wait_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TW) |-> ($stable(ad_o) && $stable(we_r) && $stable(a_r)));

  p_float_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt) |-> hlda);

  p_hold_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(hold, 3));

  p_grant_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> ($past(st) == T3 || $past(st) == IDLE));

endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, io = 1'b0, ready = 1'b1, hold = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, dev_data = '0;
  wire         ack, ale, hlda;
  wire  [7:0]  rdata;
  tri1  [7:0]  a_hi, ad;
  tri1         rd_n, wr_n, io_m, s1, s0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign ad = (rd_n == 1'b0) ? dev_data : 8'bz;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .io(io), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .a_hi(a_hi), .ad(ad),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
    .ready(ready), .hold(hold), .hlda(hlda));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic cycle(input bit w, input bit i, input logic [15:0] a,
                       input logic [7:0] d, input int nw, input int lat,
                       input bit hold_t1);
    int n;
    n = 0;
    req = 1'b1; we = w; io = i; addr = a; wdata = d;
    dev_data = a[7:0] ^ a[15:8] ^ 8'hA5;
    do begin
      step();
      n++;
    end while (!ale && n < 20);
    chk("R2 latency", n, lat);
    chk("R2 low addr", ad, a[7:0]);
    chk("R2 high addr", a_hi, a[15:8]);
    chk("R2 io_m", io_m, i);
    chk("R6 status", {s1, s0}, w ? 2'b01 : 2'b10);
    chk("R9 hlda low", hlda, 0);
    #10;
    chk("R2 ale half", ale, 0);
    if (hold_t1) hold = 1'b1;
    for (int k = 0; k <= nw; k++) begin
      @(posedge clk);
      #2 ready = (k == nw);
      #3;
      chk(w ? "R4 wr_n" : "R3 rd_n", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
      if (w) chk("R4 data", ad, d);
      chk("R5 no ack", ack, 0);
      chk("R5 addr steady", a_hi, a[15:8]);
    end
    step();
    chk(w ? "R4 wr_n T3" : "R3 rd_n T3", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
    if (w) chk("R4 data T3", ad, d);
    step();
    chk("R10 ack", ack, 1);
    if (!w) chk("R3 rdata", rdata, a[7:0] ^ a[15:8] ^ 8'hA5);
    chk("R3 strobes off", {rd_n, wr_n}, 2'b11);
    chk("R7 hlda with ack", hlda, hold_t1);
    req = 1'b0; ready = 1'b1;
    step();
    chk("R10 ack one clock", ack, 0);
  endtask

  initial begin
    logic [15:0] al [3];
    al[0] = 16'h1234; al[1] = 16'h80C3; al[2] = 16'h4E01;
    #25;
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rd_n, wr_n}, 2'b11);
    chk("R1 hlda", hlda, 0);
    chk("R1 ack", ack, 0);
    chk("R1 a_hi", a_hi, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    step();

    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 2; i++)
        for (int nw = 0; nw < 4; nw++)
          for (int x = 0; x < 3; x++)
            cycle(w[0], i[0], al[x], al[x][7:0] + 8'h3C + 8'(nw), nw, 1, 1'b0);

    // R7 R8 R9: hold arrives in T1; ack and grant share a clock
    cycle(1'b0, 1'b0, 16'h5A10, 8'h00, 2, 1, 1'b1);
    chk("R8 a_hi float", a_hi, 8'hFF);
    chk("R8 status float", {io_m, s1, s0}, 3'b111);
    hold = 1'b0;
    step(); chk("R9 hlda held 1", hlda, 1);
    step(); chk("R9 hlda held 2", hlda, 1);
    step(); chk("R9 hlda drops", hlda, 0);
    chk("R8 still float", a_hi, 8'hFF);
    #10;
    chk("R8 retake", a_hi, 8'h5A);
    #10;

    // R7: hold and pending request meet at the same idle boundary
    step();
    hold = 1'b1;
    step(); chk("R7 sync delay 1", hlda, 0);
    step(); chk("R7 sync delay 2", hlda, 0);
    req = 1'b1; we = 1'b0; io = 1'b0; addr = 16'h3377;
    step();
    chk("R7 grant wins", hlda, 1);
    chk("R7 no ale", ale, 0);
    #10;
    chk("R8 float", a_hi, 8'hFF);
    chk("R8 ale driven", ale, 0);
    #10;
    step(); chk("R7 no cycle in hold", ale, 0);
    hold = 1'b0;
    cycle(1'b0, 1'b0, 16'h3377, 8'h00, 1, 4, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule